// File: doc/BRIEF.md
# SD Command Issue and Response Unit

This unit sits between a host register bank and the bit-level serialiser that drives the SD CMD line. Software loads a 32-bit argument and then writes a command word that carries the command index, the response type and the check enables. The write to the command word is what launches the command. The unit hands the index, argument and response type to the serialiser through a request/sent handshake, and counts SD clock ticks while it waits for a response start bit. When the response arrives, the unit stores it in four 32-bit response words.

The unit tracks two inhibit flags, one for the command line and one for the data lines, and shows them together with the live DAT[3:0] levels. It also keeps a write-1-to-clear interrupt status word. This word records command completion, transfer completion, DMA events, a response timeout, CRC failure and index mismatch. Its error summary bit is the OR of the error bits.

A long (136-bit) response is stored with its CRC byte stripped. The response words therefore hold frame bits [127:8], shifted down by 8. A short response with busy keeps the data-line inhibit set until DAT0 goes high again.

Top module: `sdcmd_issue_unit`

Register map (word addresses on `wr_addr`/`rd_addr`):

| Address | Register |
|---------|----------|
| 0 | argument |
| 1 | command word |
| 2–5 | response words 0–3 |
| 6 | present state |
| 7 | interrupt status |

## Requirements
- R1: Command word fields are decoded as follows: index in bits [13:8], data-present in bit 5, index-check enable in bit 4, CRC-check enable in bit 3, response type in bits [1:0].
  - An accepted write to address 1 raises `ser_req` in the next cycle, with `ser_index` and `ser_kind` taken from that write.
  - `ser_req`, `ser_index` and `ser_arg` then stay stable until `ser_sent`.
  - Response types are encoded 0 = none, 1 = 136-bit, 2 = 48-bit, 3 = 48-bit then busy.
- R2: `ser_arg` carries the argument register value at the moment of the command write. A later write to address 0 during that command does not change `ser_arg`.
- R3: Present-state bit 0 (CMD inhibit) sets on an accepted command write. It clears when a response is received, when a timeout fires, or, for type 0, when `ser_sent` is seen. Interrupt status bit 0 (command complete) sets on the same edge, except on a timeout.
- R4: A command write is ignored while CMD inhibit is set. A type-3 write with data-present 0 is also ignored while DAT inhibit (present bit 1) is set; every other type checks only CMD inhibit. An ignored write produces no `ser_req`, and reading address 1 still returns the last accepted command word (layout as in R1, other bits 0).
- R5: If 64 `sd_tick` pulses pass after `ser_sent` with no `rsp_start`, status bit 16 (timeout) and bit 15 (error summary) set, command complete does not set, and CMD inhibit clears. A start bit seen after 63 ticks gives no timeout.
- R6: For a 48-bit response (type 2 or 3), response word 0 takes frame bits [39:8], and command complete sets.
- R7: For a 136-bit response, response words 3..0 hold frame bits [127:8], right-aligned, with word 3 bits [31:24] zero.
- R8: Status bit 19 sets when index check is enabled and frame bits [45:40] differ from the sent index. Status bit 17 sets when CRC check is enabled and `rsp_crc_ok` is low. Either error also sets bit 15. With a check disabled, the matching error never sets.
- R9: Type 3 with data-present 0 sets DAT inhibit at issue. DAT inhibit clears in the cycle after DAT0 is seen high following the response, and status bit 1 (transfer complete) sets at that point. Present bits [23:20] show `dat_lines`.
- R10: Writing the status word clears every bit written as 1 and leaves bits written as 0. Bit 15 is read-only: it reads as the OR of bits [31:16].
- R11: A command with data-present 1 sets DAT inhibit. A `xfer_done` pulse clears it and sets status bit 1. A `dma_event` pulse sets status bit 3.
- R12: A type-0 command completes on `ser_sent` and leaves the response words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| ser_req | output | 1 | Command waiting for the serialiser |
| ser_index | output | 6 | Command index to send |
| ser_arg | output | 32 | Argument to send |
| ser_kind | output | 2 | Expected response type |
| ser_sent | input | 1 | Serialiser has finished sending the command |
| sd_tick | input | 1 | One pulse per SD clock period |
| rsp_start | input | 1 | Response start bit detected |
| rsp_valid | input | 1 | Complete response frame present |
| rsp_frame | input | 136 | Raw response frame, right-aligned |
| rsp_crc_ok | input | 1 | Response CRC matched |
| xfer_done | input | 1 | Data path finished a transfer |
| dma_event | input | 1 | DMA boundary event from the data path |
| dat_lines | input | 4 | DAT[3:0] line levels |

## Verification
The bench sets the timeout window at both edges of its boundary. With 63 ticks and then a start bit, a counter that is off by one would report a false timeout. With 64 ticks, an off-by-one counter would fail to report one.

For long responses the bench uses a frame whose bytes are all distinct. A store that forgets the 8-bit CRC shift, or that orders the words wrongly, shows a mismatch in every response word.

The busy case is tested twice. First, a second busy command is attempted while DAT0 is still low; it must be rejected. Then a plain command is issued while DAT0 is low; it must be accepted. A unit that used the wrong inhibit rule would either hang software or launch a command over a busy card.

Write-1-to-clear is tested with zero writes and with partial masks. Clearing only the error detail bit must also drop the summary bit.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int ARG_W   = 32;
  localparam int IDX_W   = 6;
  localparam int FRAME_W = 136;
  localparam int WORD_W  = 32;
  localparam int N_RESP  = 4;
  localparam int ADDR_W  = 3;

  typedef enum logic [1:0] {
    RSP_NONE       = 2'd0,
    RSP_LONG       = 2'd1,
    RSP_SHORT      = 2'd2,
    RSP_SHORT_BUSY = 2'd3
  } rsp_kind_e;

  typedef struct packed {
    logic [IDX_W-1:0] index;
    logic             data_present;
    logic             idx_check;
    logic             crc_check;
    rsp_kind_e        kind;
  } cmd_word_t;

  localparam logic [ADDR_W-1:0] A_ARG   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMD   = 3'd1;
  localparam logic [ADDR_W-1:0] A_RESP0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_PRES  = 3'd6;
  localparam logic [ADDR_W-1:0] A_STS   = 3'd7;

  localparam int ST_CMD_DONE  = 0;
  localparam int ST_XFER_DONE = 1;
  localparam int ST_DMA       = 3;
  localparam int ST_ERR_SUM   = 15;
  localparam int ST_TIMEOUT   = 16;
  localparam int ST_CRC       = 17;
  localparam int ST_IDX       = 19;

  localparam int PR_CMD_INH = 0;
  localparam int PR_DAT_INH = 1;
  localparam int PR_DAT_LO  = 20;

  function automatic cmd_word_t decode_cmd(input logic [15:0] w);
    cmd_word_t c;
    c.index        = w[13:8];
    c.data_present = w[5];
    c.idx_check    = w[4];
    c.crc_check    = w[3];
    c.kind         = rsp_kind_e'(w[1:0]);
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] encode_cmd(input cmd_word_t c);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[13:8]  = c.index;
    w[5]     = c.data_present;
    w[4]     = c.idx_check;
    w[3]     = c.crc_check;
    w[1:0]   = c.kind;
    return w;
  endfunction

  // Busy-type command with no data needs both lines free; all else only CMD.
  function automatic logic may_issue(input cmd_word_t c, input logic cmd_inh,
                                     input logic dat_inh);
    if (cmd_inh) return 1'b0;
    if (c.kind == RSP_SHORT_BUSY && !c.data_present) return !dat_inh;
    return 1'b1;
  endfunction

  function automatic logic is_short(input rsp_kind_e k);
    return (k == RSP_SHORT) || (k == RSP_SHORT_BUSY);
  endfunction

  function automatic logic [IDX_W-1:0] frame_index(input logic [FRAME_W-1:0] f);
    return f[45:40];
  endfunction

  function automatic logic [WORD_W-1:0] short_payload(input logic [FRAME_W-1:0] f);
    return f[39:8];
  endfunction

  // Long frame without its CRC byte, right-aligned into 128 bits.
  function automatic logic [N_RESP*WORD_W-1:0] long_layout(input logic [FRAME_W-1:0] f);
    return {8'h00, f[127:8]};
  endfunction
endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_word,
  input  logic              cmd_inh,
  input  logic              dat_inh,
  output logic              issue,
  output cmd_word_t         word
);
  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{wr_word[15:14], wr_word[7:6], wr_word[2]};

  always_comb begin
    word  = decode_cmd(wr_word);
    issue = wr_en && (wr_addr == A_CMD) && may_issue(word, cmd_inh, dat_inh);
  end
endmodule

// File: rtl/sdcmd_sequencer.sv
module sdcmd_sequencer
  import sdcmd_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  cmd_word_t        issue_word,
  input  logic [ARG_W-1:0] arg_in,
  input  logic             ser_sent,
  input  logic             sd_tick,
  input  logic             rsp_start,
  input  logic             rsp_valid,
  input  logic [IDX_W-1:0] rsp_index,
  input  logic             rsp_crc_ok,
  output logic             ser_req,
  output logic [IDX_W-1:0] ser_index,
  output logic [ARG_W-1:0] ser_arg,
  output logic [1:0]       ser_kind,
  output cmd_word_t        cur_word,
  output logic             ev_nr_done,
  output logic             ev_rsp,
  output logic             ev_timeout,
  output logic             ev_idx_err,
  output logic             ev_crc_err
);
  localparam int CNT_W = $clog2(TIMEOUT_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CLKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT_START, S_WAIT_END} seq_state_e;

  seq_state_e       state_q, state_d;
  cmd_word_t        word_q;
  logic [ARG_W-1:0] arg_q;
  logic [CNT_W-1:0] tcnt_q;
  logic             sent_fire;

  always_comb begin
    sent_fire  = (state_q == S_SEND) && ser_sent;
    ev_nr_done = sent_fire && (word_q.kind == RSP_NONE);
    ev_timeout = (state_q == S_WAIT_START) && sd_tick && !rsp_start &&
                 (tcnt_q == CNT_LAST);
    ev_rsp     = (state_q == S_WAIT_END) && rsp_valid;
    ev_idx_err = ev_rsp && word_q.idx_check && is_short(word_q.kind) &&
                 (rsp_index != word_q.index);
    ev_crc_err = ev_rsp && word_q.crc_check && !rsp_crc_ok;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:       if (issue) state_d = S_SEND;
      S_SEND:       if (ser_sent) state_d = (word_q.kind == RSP_NONE) ? S_IDLE : S_WAIT_START;
      S_WAIT_START: if (rsp_start) state_d = S_WAIT_END;
                    else if (ev_timeout) state_d = S_IDLE;
      S_WAIT_END:   if (rsp_valid) state_d = S_IDLE;
      default:      state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      word_q  <= '0;
      arg_q   <= '0;
      tcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (issue && state_q == S_IDLE) begin
        word_q <= issue_word;
        arg_q  <= arg_in;
      end
      if (sent_fire) tcnt_q <= '0;
      else if (state_q == S_WAIT_START && sd_tick && !ev_timeout) tcnt_q <= tcnt_q + 1'b1;
    end
  end

  assign ser_req   = (state_q == S_SEND);
  assign ser_index = word_q.index;
  assign ser_arg   = arg_q;
  assign ser_kind  = word_q.kind;
  assign cur_word  = word_q;

  // R5: the tick counter never reaches the window length
  a_r5_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt_q < CNT_W'(TIMEOUT_CLKS));

  // R1, R2: an outstanding request holds its payload until sent
  a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_req && !ser_sent) |=> (ser_req && $stable(ser_index) && $stable(ser_arg)));

  // R3: at most one completion event per cycle
  a_r3_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_nr_done, ev_rsp, ev_timeout}));
endmodule

// File: rtl/sdcmd_resp_store.sv
module sdcmd_resp_store
  import sdcmd_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ev_rsp,
  input  rsp_kind_e                     kind,
  input  logic [FRAME_W-1:0]            frame,
  output logic [N_RESP-1:0][WORD_W-1:0] resp
);
  logic [N_RESP*WORD_W-1:0] long_bits;
  logic                     unused_frame;

  assign long_bits    = long_layout(frame);
  assign unused_frame = ^{frame[135:128], frame[7:0]};

  for (genvar g = 0; g < N_RESP; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        resp[g] <= '0;
      end else if (ev_rsp) begin
        if (kind == RSP_LONG) resp[g] <= long_bits[g*WORD_W +: WORD_W];
        else if (g == 0 && is_short(kind)) resp[g] <= short_payload(frame);
      end
    end
  end

  // R7: a long response leaves the top byte of word 3 zero
  a_r7_top_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rsp && kind == RSP_LONG) |=> (resp[N_RESP-1][WORD_W-1 -: 8] == 8'h00));
endmodule

// File: rtl/sdcmd_status.sv
module sdcmd_status
  import sdcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  cmd_word_t         issue_word,
  input  cmd_word_t         cur_word,
  input  logic              ev_nr_done,
  input  logic              ev_rsp,
  input  logic              ev_timeout,
  input  logic              ev_idx_err,
  input  logic              ev_crc_err,
  input  logic              dat0,
  input  logic              xfer_done,
  input  logic              dma_event,
  input  logic              w1c_en,
  input  logic [WORD_W-1:0] w1c_data,
  output logic              cmd_inh,
  output logic              dat_inh,
  output logic [WORD_W-1:0] intsts
);
  localparam logic [WORD_W-1:0] STORED_MASK =
    (WORD_W'(1) << ST_CMD_DONE) | (WORD_W'(1) << ST_XFER_DONE) |
    (WORD_W'(1) << ST_DMA) | (WORD_W'(1) << ST_TIMEOUT) |
    (WORD_W'(1) << ST_CRC) | (WORD_W'(1) << ST_IDX);

  logic              cmd_inh_q, dat_inh_q, busy_arm_q;
  logic [WORD_W-1:0] sts_q, sets, clrs;
  logic              busy_end, busy_cmd, busy_abort;

  always_comb begin
    busy_cmd   = (cur_word.kind == RSP_SHORT_BUSY) && !cur_word.data_present;
    busy_end   = busy_arm_q && dat0;
    busy_abort = ev_timeout && busy_cmd;
    sets = '0;
    sets[ST_CMD_DONE]  = ev_nr_done | ev_rsp;
    sets[ST_XFER_DONE] = busy_end | xfer_done;
    sets[ST_DMA]       = dma_event;
    sets[ST_TIMEOUT]   = ev_timeout;
    sets[ST_CRC]       = ev_crc_err;
    sets[ST_IDX]       = ev_idx_err;
    clrs = w1c_en ? (w1c_data & STORED_MASK) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_inh_q  <= 1'b0;
      dat_inh_q  <= 1'b0;
      busy_arm_q <= 1'b0;
      sts_q      <= '0;
    end else begin
      sts_q <= (sts_q & ~clrs) | sets;
      if (issue) cmd_inh_q <= 1'b1;
      else if (ev_nr_done || ev_rsp || ev_timeout) cmd_inh_q <= 1'b0;
      if (issue && (issue_word.data_present || issue_word.kind == RSP_SHORT_BUSY))
        dat_inh_q <= 1'b1;
      else if (busy_end || xfer_done || busy_abort)
        dat_inh_q <= 1'b0;
      if (ev_rsp && busy_cmd) busy_arm_q <= 1'b1;
      else if (busy_end) busy_arm_q <= 1'b0;
    end
  end

  always_comb begin
    intsts             = sts_q;
    intsts[ST_ERR_SUM] = |sts_q[WORD_W-1:16];
  end

  assign cmd_inh = cmd_inh_q;
  assign dat_inh = dat_inh_q;

  // R3: command complete only ever rises together with the inhibit release
  a_r3_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[ST_CMD_DONE]) |-> !cmd_inh_q);

  // R9, R11: the data inhibit drops only after DAT0 high, a transfer end or an abort
  a_r9_busy_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dat_inh_q) |-> ($past(busy_arm_q && dat0) || $past(xfer_done) || $past(ev_timeout)));

  // R10: the summary bit tracks the error bits
  a_r10_summary: assert property (@(posedge clk) disable iff (!rst_n)
    intsts[ST_ERR_SUM] == (intsts[ST_TIMEOUT] | intsts[ST_CRC] | intsts[ST_IDX]));
endmodule

// File: rtl/sdcmd_issue_unit.sv
module sdcmd_issue_unit
  import sdcmd_pkg::*;
#(
  parameter int TIMEOUT_CLKS = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [31:0]        wr_data,
  input  logic [2:0]         rd_addr,
  output logic [31:0]        rd_data,
  output logic               ser_req,
  output logic [5:0]         ser_index,
  output logic [31:0]        ser_arg,
  output logic [1:0]         ser_kind,
  input  logic               ser_sent,
  input  logic               sd_tick,
  input  logic               rsp_start,
  input  logic               rsp_valid,
  input  logic [135:0]       rsp_frame,
  input  logic               rsp_crc_ok,
  input  logic               xfer_done,
  input  logic               dma_event,
  input  logic [3:0]         dat_lines
);
  logic                          issue, cmd_inh, dat_inh;
  logic                          ev_nr_done, ev_rsp, ev_timeout, ev_idx_err, ev_crc_err;
  cmd_word_t                     new_word, cur_word;
  logic [ARG_W-1:0]              arg_q;
  logic [N_RESP-1:0][WORD_W-1:0] resp;
  logic [WORD_W-1:0]             intsts, present;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arg_q <= '0;
    else if (wr_en && wr_addr == A_ARG) arg_q <= wr_data;
  end

  sdcmd_decode u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_word (wr_data[15:0]),
    .cmd_inh (cmd_inh),
    .dat_inh (dat_inh),
    .issue   (issue),
    .word    (new_word)
  );

  sdcmd_sequencer #(.TIMEOUT_CLKS(TIMEOUT_CLKS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .issue_word (new_word),
    .arg_in     (arg_q),
    .ser_sent   (ser_sent),
    .sd_tick    (sd_tick),
    .rsp_start  (rsp_start),
    .rsp_valid  (rsp_valid),
    .rsp_index  (frame_index(rsp_frame)),
    .rsp_crc_ok (rsp_crc_ok),
    .ser_req    (ser_req),
    .ser_index  (ser_index),
    .ser_arg    (ser_arg),
    .ser_kind   (ser_kind),
    .cur_word   (cur_word),
    .ev_nr_done (ev_nr_done),
    .ev_rsp     (ev_rsp),
    .ev_timeout (ev_timeout),
    .ev_idx_err (ev_idx_err),
    .ev_crc_err (ev_crc_err)
  );

  sdcmd_resp_store u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev_rsp (ev_rsp),
    .kind   (cur_word.kind),
    .frame  (rsp_frame),
    .resp   (resp)
  );

  sdcmd_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .issue_word (new_word),
    .cur_word   (cur_word),
    .ev_nr_done (ev_nr_done),
    .ev_rsp     (ev_rsp),
    .ev_timeout (ev_timeout),
    .ev_idx_err (ev_idx_err),
    .ev_crc_err (ev_crc_err),
    .dat0       (dat_lines[0]),
    .xfer_done  (xfer_done),
    .dma_event  (dma_event),
    .w1c_en     (wr_en && wr_addr == A_STS),
    .w1c_data   (wr_data),
    .cmd_inh    (cmd_inh),
    .dat_inh    (dat_inh),
    .intsts     (intsts)
  );

  always_comb begin
    present = '0;
    present[PR_CMD_INH]           = cmd_inh;
    present[PR_DAT_INH]           = dat_inh;
    present[PR_DAT_LO +: 4]       = dat_lines;
  end

  always_comb begin
    unique case (rd_addr)
      A_ARG:   rd_data = arg_q;
      A_CMD:   rd_data = encode_cmd(cur_word);
      A_PRES:  rd_data = present;
      A_STS:   rd_data = intsts;
      default: rd_data = resp[rd_addr - A_RESP0];
    endcase
  end

  // R4: no new command is accepted while one is still waiting to be sent
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !ser_req);

  // R3: a pending request always has the command inhibit raised
  a_r3_req_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
    ser_req |-> cmd_inh);
endmodule

// File: tb/sdcmd_issue_unit_tb.sv
module sdcmd_issue_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic         ser_req;
  logic [5:0]   ser_index;
  logic [31:0]  ser_arg;
  logic [1:0]   ser_kind;
  logic         ser_sent = 1'b0, sd_tick = 1'b0, rsp_start = 1'b0, rsp_valid = 1'b0;
  logic [135:0] rsp_frame = '0;
  logic         rsp_crc_ok = 1'b1, xfer_done = 1'b0, dma_event = 1'b0;
  logic [3:0]   dat_lines = 4'hF;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  sdcmd_issue_unit u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ser_req(ser_req), .ser_index(ser_index),
    .ser_arg(ser_arg), .ser_kind(ser_kind), .ser_sent(ser_sent), .sd_tick(sd_tick),
    .rsp_start(rsp_start), .rsp_valid(rsp_valid), .rsp_frame(rsp_frame),
    .rsp_crc_ok(rsp_crc_ok), .xfer_done(xfer_done), .dma_event(dma_event),
    .dat_lines(dat_lines)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] cmdw(input logic [5:0] idx, input bit dp, input bit ic,
                                       input bit cc, input logic [1:0] typ);
    return {18'd0, idx, 2'b00, dp, ic, cc, 1'b0, typ};
  endfunction

  function automatic logic [135:0] short_frame(input logic [5:0] idx, input logic [31:0] pl);
    return {88'd0, 2'b00, idx, pl, 7'h00, 1'b1};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic pulse_sent();
    ser_sent = 1'b1; @(negedge clk); ser_sent = 1'b0;
  endtask

  task automatic ticks(input int n);
    sd_tick = 1'b1; repeat (n) @(negedge clk); sd_tick = 1'b0;
  endtask

  task automatic respond(input logic [135:0] f, input bit crc_ok);
    rsp_start = 1'b1; @(negedge clk); rsp_start = 1'b0;
    rsp_frame = f; rsp_crc_ok = crc_ok; rsp_valid = 1'b1;
    @(negedge clk); rsp_valid = 1'b0;
  endtask

  task automatic clear_all();
    wr(3'd7, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd6, v); chk("R9 reset present", v, 32'h00F0_0000);
    rd(3'd7, v); chk("R10 reset status", v, 32'h0);
    rd(3'd2, v); chk("R6 reset resp0", v, 32'h0);
    chk("R1 reset ser_req", {31'd0, ser_req}, 32'h0);
  endtask

  task automatic t_no_response();
    logic [31:0] v;
    wr(3'd0, 32'hCAFE_0001);
    wr(3'd1, cmdw(6'd0, 0, 0, 0, 2'd0));
    chk("R1 req raised", {31'd0, ser_req}, 32'h1);
    chk("R1 index", {26'd0, ser_index}, 32'h0);
    chk("R1 kind", {30'd0, ser_kind}, 32'h0);
    chk("R2 arg", ser_arg, 32'hCAFE_0001);
    rd(3'd6, v); chk("R3 cmd inhibit set", v, 32'h00F0_0001);
    wr(3'd0, 32'h1234_5678);
    chk("R2 arg held", ser_arg, 32'hCAFE_0001);
    wr(3'd1, cmdw(6'd9, 0, 0, 0, 2'd2));
    chk("R4 ignored while busy", {26'd0, ser_index}, 32'h0);
    pulse_sent();
    rd(3'd7, v); chk("R12 complete on sent", v, 32'h1);
    rd(3'd6, v); chk("R3 inhibit clear", v, 32'h00F0_0000);
    rd(3'd2, v); chk("R12 resp untouched", v, 32'h0);
    rd(3'd1, v); chk("R4 cmd readback", v, cmdw(6'd0, 0, 0, 0, 2'd0));
    wr(3'd7, 32'h0);
    rd(3'd7, v); chk("R10 zero write keeps", v, 32'h1);
    wr(3'd7, 32'h1);
    rd(3'd7, v); chk("R10 one clears", v, 32'h0);
  endtask

  task automatic t_short_ok();
    logic [31:0] v;
    wr(3'd0, 32'h0000_0AA0);
    wr(3'd1, cmdw(6'd17, 0, 1, 1, 2'd2));
    chk("R1 index 17", {26'd0, ser_index}, 32'd17);
    chk("R1 kind short", {30'd0, ser_kind}, 32'd2);
    pulse_sent();
    ticks(63);
    rd(3'd7, v); chk("R5 no timeout at 63", v, 32'h0);
    respond(short_frame(6'd17, 32'hDEAD_BEEF), 1'b1);
    rd(3'd2, v); chk("R6 resp0 payload", v, 32'hDEAD_BEEF);
    rd(3'd7, v); chk("R6 complete no error", v, 32'h1);
    rd(3'd6, v); chk("R3 released", v, 32'h00F0_0000);
    clear_all();
  endtask

  task automatic t_errors();
    logic [31:0] v;
    wr(3'd1, cmdw(6'd5, 0, 1, 0, 2'd2));
    pulse_sent(); ticks(2);
    respond(short_frame(6'd6, 32'h1), 1'b0);
    rd(3'd7, v); chk("R8 idx err, crc off", v, 32'h0008_8001);
    wr(3'd7, 32'h0008_0000);
    rd(3'd7, v); chk("R10 summary follows", v, 32'h1);
    clear_all();
    wr(3'd1, cmdw(6'd5, 0, 0, 1, 2'd2));
    pulse_sent();
    respond(short_frame(6'd6, 32'h2), 1'b0);
    rd(3'd7, v); chk("R8 crc err, idx off", v, 32'h0002_8001);
    wr(3'd7, 32'h0000_8000);
    rd(3'd7, v); chk("R10 summary read-only", v, 32'h0002_8001);
    clear_all();
  endtask

  task automatic t_long();
    logic [31:0]  v;
    logic [135:0] f;
    logic [127:0] exp;
    f   = {8'h3F, 32'h1122_3344, 32'h5566_7788, 32'h99AA_BBCC, 24'hDDEEFF, 8'h5A};
    exp = {8'h00, f[127:8]};
    wr(3'd1, cmdw(6'd2, 0, 0, 1, 2'd1));
    chk("R1 kind long", {30'd0, ser_kind}, 32'd1);
    pulse_sent();
    respond(f, 1'b1);
    for (int i = 0; i < 4; i++) begin
      rd(3'(2 + i), v);
      chk("R7 long word", v, exp[i*32 +: 32]);
    end
    clear_all();
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    wr(3'd1, cmdw(6'd8, 0, 0, 0, 2'd2));
    pulse_sent();
    ticks(64);
    rd(3'd7, v); chk("R5 timeout at 64", v, 32'h0001_8000);
    rd(3'd6, v); chk("R5 inhibit cleared", v, 32'h00F0_0000);
    clear_all();
  endtask

  task automatic t_busy();
    logic [31:0] v;
    dat_lines = 4'hE;
    wr(3'd1, cmdw(6'd7, 0, 0, 0, 2'd3));
    rd(3'd6, v); chk("R9 both inhibits", v, 32'h00E0_0003);
    pulse_sent();
    respond(short_frame(6'd7, 32'h900), 1'b1);
    rd(3'd6, v); chk("R9 dat held", v, 32'h00E0_0002);
    rd(3'd7, v); chk("R9 complete, busy", v, 32'h1);
    wr(3'd1, cmdw(6'd12, 0, 0, 0, 2'd3));
    chk("R4 busy cmd rejected", {31'd0, ser_req}, 32'h0);
    rd(3'd1, v); chk("R4 readback kept", v, cmdw(6'd7, 0, 0, 0, 2'd3));
    wr(3'd1, cmdw(6'd13, 0, 0, 0, 2'd2));
    chk("R4 plain cmd accepted", {31'd0, ser_req}, 32'h1);
    chk("R4 plain index", {26'd0, ser_index}, 32'd13);
    pulse_sent();
    respond(short_frame(6'd13, 32'h77), 1'b1);
    rd(3'd2, v); chk("R6 resp during busy", v, 32'h77);
    dat_lines = 4'hF;
    @(negedge clk);
    rd(3'd6, v); chk("R9 dat released", v, 32'h00F0_0000);
    rd(3'd7, v); chk("R9 xfer complete", v, 32'h3);
    clear_all();
  endtask

  task automatic t_data();
    logic [31:0] v;
    wr(3'd1, cmdw(6'd18, 1, 0, 0, 2'd2));
    pulse_sent();
    respond(short_frame(6'd18, 32'h5), 1'b1);
    rd(3'd6, v); chk("R11 dat inhibit", v, 32'h00F0_0002);
    dma_event = 1'b1; @(negedge clk); dma_event = 1'b0;
    rd(3'd7, v); chk("R11 dma bit", v, 32'h9);
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    rd(3'd6, v); chk("R11 dat cleared", v, 32'h00F0_0000);
    rd(3'd7, v); chk("R11 xfer bit", v, 32'hB);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_response();
    t_short_ok();
    t_errors();
    t_long();
    t_timeout();
    t_busy();
    t_data();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule